// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Unit

This block watches eight input lines and turns activity on them into eight interrupt request lines, one per channel, for a downstream core interrupt controller. Channel i always drives request i; downstream these land on core interrupt numbers 32 through 39. A processor configures it over a simple synchronous 32-bit register bus. Each channel works either in edge mode, where rising and falling transitions are latched until software acknowledges them, or in level mode, where the request follows the input while the input matches a programmed polarity.

Enables are kept in two banks. Software changes them only through set and clear aliases, so no read-modify-write is needed and two agents may touch different channels without a lock. The falling bank has a double role: in edge mode it enables falling-edge capture, and in level mode it selects the active polarity. The rising bank is the plain interrupt enable in level mode. Inputs pass through a two-flop synchroniser, and an edge is the synchronised value differing from its value one cycle earlier.

Each channel runs a small state machine with states CH_QUIET (nothing latched), CH_RISE (rising edge latched), CH_FALL (falling edge latched), CH_BOTH (both latched) and CH_LEVEL (level mode, nothing latched). Transitions: any state goes to CH_LEVEL while the channel's mode bit is 1; otherwise the next state is the encoding of the held rising bit (dropped by a clear) OR a new enabled rising edge, and likewise for falling, so CH_QUIET→CH_RISE/CH_FALL/CH_BOTH on capture, CH_RISE/CH_FALL/CH_BOTH→CH_QUIET or a smaller state on clear, and CH_LEVEL→CH_QUIET (or a capture state) when the mode bit returns to 0. Register word offsets (byte address, bits [1:0] must be 0): 0x00 mode, 0x04 rising/enable bank, 0x08 set rising bank, 0x0C clear rising bank, 0x10 falling/polarity bank, 0x14 set falling bank, 0x18 clear falling bank, 0x1C rising-edge status, 0x20 falling-edge status, 0x24 request status.

Top module: `pinint_top`

## Requirements
- R1: After reset every readable register (0x00, 0x04, 0x10, 0x1C, 0x20, 0x24) reads 0 and all eight requests are low.
- R2: Bit i of the mode register at 0x00 selects level mode for channel i when 1 and edge mode when 0; it is written directly and reads back as written (bits 7:0).
- R3: Writing a 1 to bit i at 0x08 (0x14) sets bit i of the bank at 0x04 (0x10); a 1 at 0x0C (0x18) clears it; zero bits leave bits unchanged; writes to 0x04 and 0x10 themselves are ignored; the four aliases read as 0.
- R4: In edge mode with bit i of 0x04 set, a rising edge on input i sets bit i of 0x1C and raises request i, which stays high until cleared.
- R5: In edge mode with bit i of 0x10 set, a falling edge on input i sets bit i of 0x20 and raises request i.
- R6: An edge whose enable bit is 0 is not latched and does not raise a request.
- R7: Writing 1 to bit i of 0x1C or 0x20 clears that latched bit; writing 1 to bit i of 0x24 clears both; zero bits have no effect; the request falls once no latched bit remains.
- R8: In level mode request i is high exactly when bit i of 0x04 is 1 and the synchronised input equals bit i of 0x10 (1 active high, 0 active low), and it follows the input live; 0x24 reads the eight request lines.
- R9: Clearing bit i of 0x04 masks a level-mode channel at once; setting it again re-raises the request if the level is still active.
- R10: A level-mode channel latches no edges (its 0x1C and 0x20 bits read 0), and writes to its status bits have no effect.
- R11: An enabled edge captured in the same cycle as a write that clears the same status bit leaves the bit set.
- R12: Switching a channel into level mode discards its latched edges, and switching it back to edge mode starts it with nothing latched.
- R13: Request i depends only on channel i; activity on one channel never changes another channel's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| pin_in | input | 8 | Asynchronous watched input lines |
| irq_out | output | 8 | Interrupt requests, bit i from channel i |

## Verification
On every cycle the assertions check that an enabled edge is captured in the following cycle even when a clear collides with it, that a latched edge persists until cleared, that a clear without a new edge empties the bit, that a level-mode channel never holds a latched edge, that a disabled level channel keeps its request low, and that an edge-mode request only rises after a captured edge. The alias arithmetic of the enable banks, the polarity meaning of the falling bank, the live following of a level input, the re-raise on unmask, the discard of latched edges on a mode switch and the isolation between channels are shown by the bench's scenarios through register reads and the request lines.

// File: rtl/pinint_pkg.sv
package pinint_pkg;

    // Per-channel tracker states
    typedef enum logic [2:0] {
        CH_QUIET = 3'd0,
        CH_RISE  = 3'd1,
        CH_FALL  = 3'd2,
        CH_BOTH  = 3'd3,
        CH_LEVEL = 3'd4
    } ch_state_e;

    // Register word indices (byte offset / 4)
    localparam int unsigned W_MODE  = 0;
    localparam int unsigned W_REN   = 1;
    localparam int unsigned W_RSET  = 2;
    localparam int unsigned W_RCLR  = 3;
    localparam int unsigned W_FEN   = 4;
    localparam int unsigned W_FSET  = 5;
    localparam int unsigned W_FCLR  = 6;
    localparam int unsigned W_RSTAT = 7;
    localparam int unsigned W_FSTAT = 8;
    localparam int unsigned W_IST   = 9;

endpackage

// File: rtl/pinint_sync.sv
module pinint_sync #(
    parameter int unsigned N_CH   = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pin_in,
    output logic [N_CH-1:0] lvl,
    output logic [N_CH-1:0] rise_raw,
    output logic [N_CH-1:0] fall_raw
);

    logic [N_CH-1:0] stage_q [STAGES];
    logic [N_CH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= '0;
            end
            prev_q <= '0;
        end else begin
            stage_q[0] <= pin_in;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign lvl      = stage_q[STAGES-1];
    assign rise_raw = stage_q[STAGES-1] & ~prev_q;
    assign fall_raw = ~stage_q[STAGES-1] & prev_q;

endmodule

// File: rtl/pinint_chan.sv
module pinint_chan
    import pinint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_mode,
    input  logic rise_hit,
    input  logic fall_hit,
    input  logic clr_rise,
    input  logic clr_fall,
    output logic rise_st,
    output logic fall_st
);

    ch_state_e state_q;
    ch_state_e state_d;
    logic      nxt_r;
    logic      nxt_f;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a fresh capture outranks a clear in the same cycle
    always_comb begin
        nxt_r = (rise_st & ~clr_rise) | rise_hit;
        nxt_f = (fall_st & ~clr_fall) | fall_hit;
        if (lvl_mode) begin
            state_d = CH_LEVEL;
        end else begin
            unique case ({nxt_r, nxt_f})
                2'b00:   state_d = CH_QUIET;
                2'b10:   state_d = CH_RISE;
                2'b01:   state_d = CH_FALL;
                default: state_d = CH_BOTH;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (state_q)
            CH_RISE:  begin rise_st = 1'b1; fall_st = 1'b0; end
            CH_FALL:  begin rise_st = 1'b0; fall_st = 1'b1; end
            CH_BOTH:  begin rise_st = 1'b1; fall_st = 1'b1; end
            CH_LEVEL: begin rise_st = 1'b0; fall_st = 1'b0; end
            default:  begin rise_st = 1'b0; fall_st = 1'b0; end
        endcase
    end

endmodule

// File: rtl/pinint_regs.sv
module pinint_regs
    import pinint_pkg::*;
#(
    parameter int unsigned N_CH = 8,
    parameter int unsigned AW   = 6,
    parameter int unsigned DW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [N_CH-1:0] rise_st,
    input  logic [N_CH-1:0] fall_st,
    input  logic [N_CH-1:0] irq_vec,
    output logic [N_CH-1:0] mode_q,
    output logic [N_CH-1:0] en_r_q,
    output logic [N_CH-1:0] en_f_q,
    output logic [N_CH-1:0] clr_rise,
    output logic [N_CH-1:0] clr_fall,
    output logic [DW-1:0]   bus_rdata
);

    localparam int unsigned IDX_W = AW - 2;

    logic [IDX_W-1:0] idx;
    logic             acc;
    logic             wr;
    logic [N_CH-1:0]  wd;
    logic [N_CH-1:0]  rd_small;
    logic             unused_wdata;

    assign idx          = bus_addr[AW-1:2];
    assign acc          = bus_en && (bus_addr[1:0] == 2'b00);
    assign wr           = acc && bus_we;
    assign wd           = bus_wdata[N_CH-1:0];
    assign unused_wdata = ^bus_wdata[DW-1:N_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            en_r_q <= '0;
            en_f_q <= '0;
        end else if (wr) begin
            unique case (idx)
                IDX_W'(W_MODE): mode_q <= wd;
                IDX_W'(W_RSET): en_r_q <= en_r_q | wd;
                IDX_W'(W_RCLR): en_r_q <= en_r_q & ~wd;
                IDX_W'(W_FSET): en_f_q <= en_f_q | wd;
                IDX_W'(W_FCLR): en_f_q <= en_f_q & ~wd;
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_rise = '0;
        clr_fall = '0;
        if (wr) begin
            if (idx == IDX_W'(W_RSTAT) || idx == IDX_W'(W_IST)) clr_rise = wd;
            if (idx == IDX_W'(W_FSTAT) || idx == IDX_W'(W_IST)) clr_fall = wd;
        end
    end

    always_comb begin
        rd_small = '0;
        if (acc && !bus_we) begin
            unique case (idx)
                IDX_W'(W_MODE):  rd_small = mode_q;
                IDX_W'(W_REN):   rd_small = en_r_q;
                IDX_W'(W_FEN):   rd_small = en_f_q;
                IDX_W'(W_RSTAT): rd_small = rise_st;
                IDX_W'(W_FSTAT): rd_small = fall_st;
                IDX_W'(W_IST):   rd_small = irq_vec;
                default:         rd_small = '0;
            endcase
        end
    end

    assign bus_rdata = {{(DW-N_CH){1'b0}}, rd_small};

endmodule

// File: rtl/pinint_top.sv
module pinint_top #(
    parameter int unsigned N_CH        = 8,
    parameter int unsigned AW          = 6,
    parameter int unsigned DW          = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [N_CH-1:0] pin_in,
    output logic [N_CH-1:0] irq_out
);

    logic [N_CH-1:0] lvl;
    logic [N_CH-1:0] rise_raw;
    logic [N_CH-1:0] fall_raw;
    logic [N_CH-1:0] rise_hit;
    logic [N_CH-1:0] fall_hit;
    logic [N_CH-1:0] mode_q;
    logic [N_CH-1:0] en_r_q;
    logic [N_CH-1:0] en_f_q;
    logic [N_CH-1:0] clr_rise;
    logic [N_CH-1:0] clr_fall;
    logic [N_CH-1:0] rise_st;
    logic [N_CH-1:0] fall_st;

    pinint_sync #(.N_CH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .lvl      (lvl),
        .rise_raw (rise_raw),
        .fall_raw (fall_raw)
    );

    pinint_regs #(.N_CH(N_CH), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rise_st   (rise_st),
        .fall_st   (fall_st),
        .irq_vec   (irq_out),
        .mode_q    (mode_q),
        .en_r_q    (en_r_q),
        .en_f_q    (en_f_q),
        .clr_rise  (clr_rise),
        .clr_fall  (clr_fall),
        .bus_rdata (bus_rdata)
    );

    // Edge capture only in edge mode and only when enabled
    assign rise_hit = rise_raw & en_r_q & ~mode_q;
    assign fall_hit = fall_raw & en_f_q & ~mode_q;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        pinint_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_mode (mode_q[i]),
            .rise_hit (rise_hit[i]),
            .fall_hit (fall_hit[i]),
            .clr_rise (clr_rise[i]),
            .clr_fall (clr_fall[i]),
            .rise_st  (rise_st[i]),
            .fall_st  (fall_st[i])
        );

        // Level: live match against polarity; edge: any latched edge
        assign irq_out[i] = mode_q[i] ? ((lvl[i] ~^ en_f_q[i]) & en_r_q[i])
                                      : (rise_st[i] | fall_st[i]);
    end

endmodule

// File: rtl/pinint_chk.sv
module pinint_chk #(
    parameter int unsigned N_CH = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] mode_q,
    input logic [N_CH-1:0] en_r_q,
    input logic [N_CH-1:0] rise_hit,
    input logic [N_CH-1:0] fall_hit,
    input logic [N_CH-1:0] clr_rise,
    input logic [N_CH-1:0] clr_fall,
    input logic [N_CH-1:0] rise_st,
    input logic [N_CH-1:0] fall_st,
    input logic [N_CH-1:0] irq_out
);

    for (genvar i = 0; i < N_CH; i++) begin : g_a
        p_rise_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
            rise_hit[i] |=> rise_st[i]);

        p_fall_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
            fall_hit[i] |=> fall_st[i]);

        p_rise_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rise_st[i] && !clr_rise[i] && !mode_q[i]) |=> rise_st[i]);

        p_rise_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_rise[i] && !rise_hit[i]) |=> !rise_st[i]);

        p_fall_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_fall[i] && !fall_hit[i]) |=> !fall_st[i]);

        p_level_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[i] && $past(mode_q[i])) |-> (!rise_st[i] && !fall_st[i]));

        p_level_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[i] && !en_r_q[i]) |-> !irq_out[i]);

        p_edge_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(irq_out[i]) && !mode_q[i] && !$past(mode_q[i]))
            |-> $past(rise_hit[i] || fall_hit[i]));
    end

endmodule

bind pinint_top pinint_chk #(.N_CH(N_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .en_r_q   (en_r_q),
    .rise_hit (rise_hit),
    .fall_hit (fall_hit),
    .clr_rise (clr_rise),
    .clr_fall (clr_fall),
    .rise_st  (rise_st),
    .fall_st  (fall_st),
    .irq_out  (irq_out)
);

// File: tb/sim_pinint_top.sv
`timescale 1ns/100ps
module sim_pinint_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit mon_go = 1'b0;

    typedef struct {
        bit          is_rd;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];

    always #2.5 clk = ~clk;

    pinint_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .irq_out   (irq_out)
    );

    // Monitor: pops expected items and compares mid-cycle
    always @(negedge clk) begin
        if (mon_go && q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_rd ? bus_rdata : {24'b0, irq_out};
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk_rd(input logic [5:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        q.push_back('{1'b1, e, t});
        mon_go = 1'b1;
        @(posedge clk); #1;
        bus_en = 1'b0; mon_go = 1'b0;
    endtask

    task automatic chk_irq(input logic [7:0] e, input string t);
        @(posedge clk); #1;
        q.push_back('{1'b0, {24'b0, e}, t});
        mon_go = 1'b1;
        @(posedge clk); #1;
        mon_go = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(posedge clk); #1;
        pin_in = v;
        repeat (4) @(posedge clk);
    endtask

    // Pin change timed so its capture edge meets a status-clear write
    task automatic collide(input logic [7:0] v, input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        pin_in = v;
        @(posedge clk);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk_rd(6'h00, 32'h0, "R1 mode");
        chk_rd(6'h04, 32'h0, "R1 rise bank");
        chk_rd(6'h10, 32'h0, "R1 fall bank");
        chk_rd(6'h1C, 32'h0, "R1 rise status");
        chk_rd(6'h20, 32'h0, "R1 fall status");
        chk_rd(6'h24, 32'h0, "R1 request status");
        chk_irq(8'h00, "R1 requests");

        // R3: set/clear aliases
        wr(6'h08, 32'h0F);
        chk_rd(6'h04, 32'h0F, "R3 set");
        wr(6'h08, 32'h30);
        chk_rd(6'h04, 32'h3F, "R3 set zeros keep");
        wr(6'h0C, 32'h05);
        chk_rd(6'h04, 32'h3A, "R3 clear");
        wr(6'h04, 32'hFF);
        chk_rd(6'h04, 32'h3A, "R3 direct write ignored");
        wr(6'h14, 32'hC0);
        wr(6'h18, 32'h40);
        chk_rd(6'h10, 32'h80, "R3 fall bank set/clear");
        chk_rd(6'h08, 32'h0, "R3 alias reads zero");

        // R4, R13: rising edge on ch1
        set_pins(8'h02);
        chk_rd(6'h1C, 32'h02, "R4 rise latched");
        chk_irq(8'h02, "R13 only ch1 request");

        // R6: disabled rising edge on ch0
        set_pins(8'h03);
        chk_rd(6'h1C, 32'h02, "R6 disabled edge");
        chk_irq(8'h02, "R6 no request");

        // R5: falling edge on ch7 (its rise disabled)
        set_pins(8'h83);
        set_pins(8'h03);
        chk_rd(6'h20, 32'h80, "R5 fall latched");
        chk_rd(6'h1C, 32'h02, "R5 rise unaffected");
        chk_irq(8'h82, "R5 request");

        // R7: clearing
        wr(6'h1C, 32'h00);
        chk_irq(8'h82, "R7 zero write no effect");
        wr(6'h1C, 32'h02);
        chk_rd(6'h1C, 32'h0, "R7 rise cleared");
        chk_irq(8'h80, "R7 ch1 dropped");
        wr(6'h24, 32'h80);
        chk_rd(6'h20, 32'h0, "R7 fall cleared via request status");
        chk_irq(8'h00, "R7 all dropped");
        wr(6'h14, 32'h08);
        set_pins(8'h0B);
        set_pins(8'h03);
        chk_rd(6'h1C, 32'h08, "R7 ch3 rise");
        chk_rd(6'h20, 32'h08, "R7 ch3 fall");
        wr(6'h24, 32'h08);
        chk_rd(6'h1C, 32'h0, "R7 both cleared rise");
        chk_rd(6'h20, 32'h0, "R7 both cleared fall");
        chk_irq(8'h00, "R7 ch3 dropped");

        // R11: capture collides with clear on ch4
        collide(8'h13, 6'h1C, 32'h10);
        chk_rd(6'h1C, 32'h10, "R11 capture wins");
        chk_irq(8'h10, "R11 request");
        wr(6'h24, 32'h10);
        chk_irq(8'h00, "R11 cleared later");

        // R2, R8: level mode on ch0, ch1
        wr(6'h00, 32'h03);
        chk_rd(6'h00, 32'h03, "R2 mode readback");
        chk_irq(8'h00, "R8 active low, input high");
        wr(6'h14, 32'h02);
        chk_irq(8'h02, "R8 active high");
        chk_rd(6'h24, 32'h02, "R8 request status");
        set_pins(8'h11);
        chk_irq(8'h00, "R8 follows low");
        set_pins(8'h13);
        chk_irq(8'h02, "R8 follows high");

        // R10: status writes ignored in level mode
        wr(6'h24, 32'h02);
        chk_irq(8'h02, "R10 clear ignored");
        chk_rd(6'h1C, 32'h0, "R10 no latch");

        // R9: mask and unmask
        wr(6'h0C, 32'h02);
        chk_irq(8'h00, "R9 masked");
        wr(6'h08, 32'h02);
        chk_irq(8'h02, "R9 re-raised");

        // R8: active-low on ch0
        wr(6'h08, 32'h01);
        chk_irq(8'h02, "R8 ch0 high inactive");
        set_pins(8'h12);
        chk_irq(8'h03, "R8 ch0 low active");

        // R12: mode switch discards latched edges (ch5)
        set_pins(8'h32);
        chk_rd(6'h1C, 32'h20, "R12 ch5 latched");
        chk_irq(8'h23, "R12 before switch");
        wr(6'h00, 32'h23);
        chk_rd(6'h1C, 32'h0, "R12 discarded");
        chk_irq(8'h03, "R12 level ch5 inactive");
        wr(6'h00, 32'h03);
        chk_rd(6'h1C, 32'h0, "R12 back to edge empty");
        chk_rd(6'h24, 32'h03, "R12 request status");

        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1..: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule